// File: doc/BRIEF.md
# Frame-Sync Source Selector

This block decides whether an external frame-sync input feeds the output-clock alignment logic, and which of three sync pins supplies it. It looks at the lock state of the clock-recovery loop, a frame-sync enable bit, a 4-bit source field, an auto-enable bit, a 3-bit sync-source field and the index of the reference that the loop currently tracks. From these it produces a mode code and a pin choice. The pin choice is given both as an encoded value and as a one-hot vector. The value "internal" means that no pin is used.

The top two bits of the source field pick the mode. When both are 1, the block runs a three-pin automatic mode. In that mode the pin follows the selected reference. The auto-enable bit then takes a second role: it asks the block to clear the enable bit whenever the selected reference changes. The block raises a one-cycle clear pulse for that purpose, and whatever holds the enable bit acts on it.

All outputs are registered. Each one reflects the inputs seen at the previous clock edge.

Top module: `fs_src_sel`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, the outputs are as follows: `fs_mode` = 0 (disabled), `pin_sel` = 0 (internal), `pin_onehot` = 0 and `enable_clear` = 0.
- R2: If `dpll_state` is not 3'b100 (locked), the next outputs are `fs_mode` = 0 and `pin_sel` = 0, whatever the other inputs hold.
- R3: If `fs_enable` is 0, the next outputs are `fs_mode` = 0 and `pin_sel` = 0, whatever the other inputs hold.
- R4: Manual mode applies when the loop is locked, `fs_enable` = 1, `src_field[3:2]` != 2'b11 and `auto_en` = 0. In that case the next outputs are `fs_mode` = 1 and `pin_sel` = 1 (SYNC1).
- R5: Single-pin automatic mode applies when the loop is locked, `fs_enable` = 1, `src_field[3:2]` != 2'b11 and `auto_en` = 1. In that case the next `fs_mode` is 2. The next `pin_sel` is 1 when `sel_ref` equals `src_field`, and 0 otherwise.
- R6: Three-pin mode applies when the loop is locked, `fs_enable` = 1 and `src_field[3:2]` = 2'b11, whatever the value of `auto_en`. In that case the next `fs_mode` is 3. With `sync_src[2]` = 0, references 3 and 5 select `pin_sel` = 1, and references 4 and 6 select `pin_sel` = 2.
- R7: In three-pin mode with `sync_src[2]` = 1, the choice depends on `sync_src[0]`. When `sync_src[0]` = 0, reference 3 selects 1 and reference 4 selects 2. When `sync_src[0]` = 1, reference 5 selects 1 and reference 6 selects 2. The other references of the 3..6 group select 0.
- R8: In three-pin mode, reference 9 selects `pin_sel` = 3 (SYNC3) for any `sync_src`. Every reference not named in R6 or R7 selects 0.
- R9: `enable_clear` is high for exactly one cycle, one clock after `sel_ref` differs from its value at the previous clock edge. This happens only while the inputs give three-pin mode with `auto_en` = 1. No pulse follows the first edge after reset.
- R10: `pin_onehot[i]` is 1 exactly when `pin_sel` = i+1. At most one bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dpll_state | input | 3 | Lock state code of the clock-recovery loop (3'b100 means locked) |
| fs_enable | input | 1 | External frame-sync enable |
| src_field | input | 4 | Source field; 11XX selects three-pin mode, other values name a reference |
| auto_en | input | 1 | Auto-enable; in three-pin mode, requests an enable clear on a reference change |
| sync_src | input | 3 | Pairing of references to pins in three-pin mode |
| sel_ref | input | 4 | Index of the currently selected reference |
| fs_mode | output | 2 | 0 disabled, 1 manual, 2 single-pin auto, 3 three-pin auto |
| pin_sel | output | 2 | 0 internal, 1 SYNC1, 2 SYNC2, 3 SYNC3 |
| pin_onehot | output | 3 | One-hot pin select, bit 0 = SYNC1 |
| enable_clear | output | 1 | One-cycle request to clear the enable bit |

## Verification
The mode, the pin select and the clear pulse are all due one clock after the inputs that cause them. The bench therefore drives each input set on a falling edge and compares the outputs on the next falling edge, after exactly one rising edge. The expected clear pulse needs the reference from the step before, so the bench keeps the previously driven reference. It marks that reference as invalid for the first step after reset, which matches the rule that no pulse follows the first edge.

// File: rtl/fs_sel_pkg.sv
// Package: shared widths, codes and enums for the frame-sync source selector.
// Assumes the source field and the reference index have the same width.
package fs_sel_pkg;
    localparam int REF_W    = 4;
    localparam int STATE_W  = 3;
    localparam int NUM_PINS = 3;
    localparam logic [STATE_W-1:0] LOCK_CODE = 3'b100;

    typedef enum logic [1:0] {
        FS_OFF    = 2'd0,
        FS_MANUAL = 2'd1,
        FS_AUTO   = 2'd2,
        FS_TRIPLE = 2'd3
    } fs_mode_e;

    typedef enum logic [1:0] {
        PIN_INT = 2'd0,
        PIN_S1  = 2'd1,
        PIN_S2  = 2'd2,
        PIN_S3  = 2'd3
    } fs_pin_e;
endpackage

// File: rtl/fs_mode_decode.sv
// Module: fs_mode_decode
// Decodes the operating mode from the lock state, the enable bit, the source
// field and the auto-enable bit. It also gives the pin choice for the
// single-pin modes. Purely combinational; the top module registers the result.
// Assumes the source field and the reference index have the same width.
module fs_mode_decode
    import fs_sel_pkg::*;
#(
    parameter logic [STATE_W-1:0] LOCKED = LOCK_CODE
) (
    input  logic [STATE_W-1:0] dpll_state,
    input  logic               fs_enable,
    input  logic [REF_W-1:0]   src_field,
    input  logic               auto_en,
    input  logic [REF_W-1:0]   sel_ref,
    output fs_mode_e           mode_o,
    output fs_pin_e            single_pin_o
);
    localparam int TOP_HI = REF_W - 1;
    localparam int TOP_LO = REF_W - 2;

    logic active;
    logic triple;

    // Purpose: decide whether frame sync is live and which mode applies.
    always_comb begin
        active       = (dpll_state == LOCKED) && fs_enable;
        triple       = (src_field[TOP_HI:TOP_LO] == 2'b11);
        mode_o       = FS_OFF;
        single_pin_o = PIN_INT;
        if (active) begin
            if (triple) begin
                mode_o = FS_TRIPLE;
            end else if (auto_en) begin
                mode_o       = FS_AUTO;
                single_pin_o = (sel_ref == src_field) ? PIN_S1 : PIN_INT;
            end else begin
                mode_o       = FS_MANUAL;
                single_pin_o = PIN_S1;
            end
        end
    end
endmodule

// File: rtl/fs_pin_map.sv
// Module: fs_pin_map
// Maps the selected reference onto one of the three sync pins for the
// three-pin mode. The sync-source field decides the pairing of references
// to pins. Purely combinational.
// Assumes the reference indices fit in REF_W bits.
module fs_pin_map
    import fs_sel_pkg::*;
#(
    parameter int REF_A = 3,
    parameter int REF_B = 4,
    parameter int REF_C = 5,
    parameter int REF_D = 6,
    parameter int REF_E = 9
) (
    input  logic [2:0]       sync_src,
    input  logic [REF_W-1:0] sel_ref,
    output fs_pin_e          pin_o
);
    localparam logic [REF_W-1:0] RA = REF_W'(REF_A);
    localparam logic [REF_W-1:0] RB = REF_W'(REF_B);
    localparam logic [REF_W-1:0] RC = REF_W'(REF_C);
    localparam logic [REF_W-1:0] RD = REF_W'(REF_D);
    localparam logic [REF_W-1:0] RE = REF_W'(REF_E);

    // Purpose: look up the pin for the current reference and pairing.
    always_comb begin
        pin_o = PIN_INT;
        if (sel_ref == RE) begin
            pin_o = PIN_S3;
        end else begin
            casez (sync_src)
                3'b0??: begin
                    if (sel_ref == RA || sel_ref == RC)      pin_o = PIN_S1;
                    else if (sel_ref == RB || sel_ref == RD) pin_o = PIN_S2;
                end
                3'b1?0: begin
                    if (sel_ref == RA)      pin_o = PIN_S1;
                    else if (sel_ref == RB) pin_o = PIN_S2;
                end
                default: begin
                    if (sel_ref == RC)      pin_o = PIN_S1;
                    else if (sel_ref == RD) pin_o = PIN_S2;
                end
            endcase
        end
    end
endmodule

// File: rtl/fs_ref_watch.sv
// Module: fs_ref_watch
// Keeps the reference index from the previous clock edge. Raises a one-cycle
// clear pulse when the index differs and the arm input is high.
// Assumes a synchronous, active-low reset. The first edge after reset only
// loads the history and never raises a pulse.
module fs_ref_watch
    import fs_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [REF_W-1:0] sel_ref,
    output logic             clear_o
);
    logic [REF_W-1:0] ref_q;
    logic             hist_vld;
    logic             changed;

    // Purpose: compare the present reference against the stored one.
    always_comb begin
        changed = hist_vld && (sel_ref != ref_q);
    end

    // Purpose: keep the reference history and register the clear pulse.
    always_ff @(posedge clk) begin
        ref_q <= sel_ref;
        if (!rst_n) begin
            hist_vld <= 1'b0;
            clear_o  <= 1'b0;
        end else begin
            hist_vld <= 1'b1;
            clear_o  <= arm && changed;
        end
    end

    // R9
    clear_after_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> (ref_q != $past(ref_q)));
endmodule

// File: rtl/fs_src_sel.sv
// Module: fs_src_sel (top)
// Chooses the frame-sync mode and sync pin from the loop state and control
// fields. Requests an enable clear when the reference changes in three-pin
// mode with auto-enable set. All outputs are registered, one clock after
// their inputs.
// Assumes a synchronous, active-low reset.
module fs_src_sel
    import fs_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] dpll_state,
    input  logic               fs_enable,
    input  logic [REF_W-1:0]   src_field,
    input  logic               auto_en,
    input  logic [2:0]         sync_src,
    input  logic [REF_W-1:0]   sel_ref,
    output logic [1:0]         fs_mode,
    output logic [1:0]         pin_sel,
    output logic [NUM_PINS-1:0] pin_onehot,
    output logic               enable_clear
);
    fs_mode_e mode_nxt;
    fs_pin_e  single_pin;
    fs_pin_e  triple_pin;
    fs_pin_e  pin_nxt;
    fs_mode_e mode_q;
    fs_pin_e  pin_q;
    logic     arm;

    fs_mode_decode u_mode (
        .dpll_state   (dpll_state),
        .fs_enable    (fs_enable),
        .src_field    (src_field),
        .auto_en      (auto_en),
        .sel_ref      (sel_ref),
        .mode_o       (mode_nxt),
        .single_pin_o (single_pin)
    );

    fs_pin_map u_map (
        .sync_src (sync_src),
        .sel_ref  (sel_ref),
        .pin_o    (triple_pin)
    );

    // Purpose: choose the pin source by mode and arm the clear request.
    always_comb begin
        pin_nxt = (mode_nxt == FS_TRIPLE) ? triple_pin : single_pin;
        arm     = (mode_nxt == FS_TRIPLE) && auto_en;
    end

    fs_ref_watch u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .sel_ref (sel_ref),
        .clear_o (enable_clear)
    );

    // Purpose: register mode and pin; reset to disabled and internal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= FS_OFF;
            pin_q  <= PIN_INT;
        end else begin
            mode_q <= mode_nxt;
            pin_q  <= pin_nxt;
        end
    end

    assign fs_mode = mode_q;
    assign pin_sel = pin_q;

    // Purpose: expand the encoded pin into a one-hot vector.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_onehot
        assign pin_onehot[i] = (pin_q == fs_pin_e'(i + 1));
    end

    // R2
    unlocked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dpll_state != LOCK_CODE) |=> (fs_mode == FS_OFF && pin_sel == PIN_INT));
    // R3
    disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_enable |=> (fs_mode == FS_OFF && pin_sel == PIN_INT && !enable_clear));
    // R4
    manual_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_mode == FS_MANUAL) |-> (pin_sel == PIN_S1));
    // R5
    auto_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_mode == FS_AUTO) |-> (pin_sel == PIN_S1 || pin_sel == PIN_INT));
    // R8
    sync3_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == PIN_S3) |-> (fs_mode == FS_TRIPLE));
    // R9
    clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_clear |-> (fs_mode == FS_TRIPLE));
    // R10
    onehot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_onehot) && ((pin_onehot == '0) == (pin_sel == PIN_INT)));
endmodule

// File: tb/fs_src_sel_tb.sv
module fs_src_sel_tb;
    localparam time CLK_P = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dpll_state = 3'd0;
    logic       fs_enable = 1'b0;
    logic [3:0] src_field = 4'd0;
    logic       auto_en = 1'b0;
    logic [2:0] sync_src = 3'd0;
    logic [3:0] sel_ref = 4'd0;
    logic [1:0] fs_mode;
    logic [1:0] pin_sel;
    logic [2:0] pin_onehot;
    logic       enable_clear;

    int checks = 0;
    int errors = 0;
    logic [3:0] prev_ref = 4'd0;
    bit         have_prev = 1'b0;
    bit         done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fs_src_sel u_dut (
        .clk(clk), .rst_n(rst_n), .dpll_state(dpll_state), .fs_enable(fs_enable),
        .src_field(src_field), .auto_en(auto_en), .sync_src(sync_src),
        .sel_ref(sel_ref), .fs_mode(fs_mode), .pin_sel(pin_sel),
        .pin_onehot(pin_onehot), .enable_clear(enable_clear)
    );

    function automatic logic [1:0] map3(input logic [2:0] ss, input logic [3:0] r);
        if (r == 4'd9) return 2'd3;
        if (!ss[2]) begin
            if (r == 4'd3 || r == 4'd5) return 2'd1;
            if (r == 4'd4 || r == 4'd6) return 2'd2;
        end else if (!ss[0]) begin
            if (r == 4'd3) return 2'd1;
            if (r == 4'd4) return 2'd2;
        end else begin
            if (r == 4'd5) return 2'd1;
            if (r == 4'd6) return 2'd2;
        end
        return 2'd0;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge (one rising edge later).
    task automatic step(input logic [2:0] st, input logic en, input logic [3:0] src,
                        input logic ae, input logic [2:0] ss, input logic [3:0] r);
        logic [1:0] em;
        logic [1:0] ep;
        logic       ec;
        string      tag;
        dpll_state = st; fs_enable = en; src_field = src;
        auto_en = ae; sync_src = ss; sel_ref = r;
        em = 2'd0; ep = 2'd0; ec = 1'b0;
        if (st != 3'b100) tag = "R2";
        else if (!en) tag = "R3";
        else if (src[3:2] == 2'b11) begin
            em = 2'd3; ep = map3(ss, r);
            tag = (r == 4'd9 || ep == 2'd0) ? "R8" : (ss[2] ? "R7" : "R6");
            ec = ae && have_prev && (r != prev_ref);
        end else if (ae) begin
            em = 2'd2; ep = (r == src) ? 2'd1 : 2'd0; tag = "R5";
        end else begin
            em = 2'd1; ep = 2'd1; tag = "R4";
        end
        @(negedge clk);
        check(tag, "fs_mode", fs_mode, em);
        check(tag, "pin_sel", pin_sel, ep);
        check("R10", "pin_onehot", pin_onehot, (ep == 0) ? 0 : (1 << (ep - 1)));
        check("R9", "enable_clear", enable_clear, ec);
        prev_ref = r;
        have_prev = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at reset values while reset is low
        dpll_state = 3'b100; fs_enable = 1'b1; src_field = 4'hC; auto_en = 1'b1; sel_ref = 4'd9;
        repeat (3) @(negedge clk);
        check("R1", "fs_mode", fs_mode, 0);
        check("R1", "pin_sel", pin_sel, 0);
        check("R1", "pin_onehot", pin_onehot, 0);
        check("R1", "enable_clear", enable_clear, 0);
        rst_n = 1'b1;
        // R1/R9: first edge after reset, reference differs from the reset-time one: no pulse
        step(3'b100, 1'b1, 4'hC, 1'b1, 3'b000, 4'd3);
        // R9: reference change in three-pin mode with auto-enable
        step(3'b100, 1'b1, 4'hC, 1'b1, 3'b000, 4'd4);
        step(3'b100, 1'b1, 4'hC, 1'b1, 3'b000, 4'd4);
        // R9: change with auto-enable low: no pulse
        step(3'b100, 1'b1, 4'hD, 1'b0, 3'b000, 4'd9);
        // R6, R7, R8 directed
        step(3'b100, 1'b1, 4'hF, 1'b0, 3'b011, 4'd5);
        step(3'b100, 1'b1, 4'hF, 1'b0, 3'b110, 4'd3);
        step(3'b100, 1'b1, 4'hF, 1'b0, 3'b110, 4'd5);
        step(3'b100, 1'b1, 4'hF, 1'b0, 3'b101, 4'd6);
        step(3'b100, 1'b1, 4'hF, 1'b0, 3'b111, 4'd9);
        step(3'b100, 1'b1, 4'hF, 1'b0, 3'b000, 4'd7);
        // R4, R5 directed
        step(3'b100, 1'b1, 4'h5, 1'b0, 3'b000, 4'd1);
        step(3'b100, 1'b1, 4'h5, 1'b1, 3'b000, 4'd5);
        step(3'b100, 1'b1, 4'h5, 1'b1, 3'b000, 4'd6);
        // R2, R3: unlocked or disabled with a three-pin setting and a reference change
        step(3'b011, 1'b1, 4'hC, 1'b1, 3'b000, 4'd9);
        step(3'b100, 1'b0, 4'hC, 1'b1, 3'b000, 4'd3);
        // Constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            logic [2:0] st;
            logic [3:0] src;
            logic [3:0] r;
            st  = ($urandom_range(0, 3) != 0) ? 3'b100 : 3'($urandom);
            src = ($urandom_range(0, 1) != 0) ? {2'b11, 2'($urandom)} : 4'($urandom);
            r   = ($urandom_range(0, 3) != 0) ? 4'($urandom_range(3, 9)) : 4'($urandom);
            step(st, ($urandom_range(0, 5) != 0), src, 1'($urandom), 3'($urandom), r);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule